// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives the clock sent to a contact card from the crystal clock. It divides the crystal rate by 1, 2, 4 or 8, chosen by a two-bit select code. It can change ratio while running without cutting any high or low phase short. A run input from the activation sequencer starts and stops the card clock. A stopped card clock always rests low.

The select bits and the run input are asynchronous to the crystal clock, so they pass through a synchronizer first. A controller adopts a new setting only at a safe point: when the divided phase is low and its half-period count has expired, when the divide-by-1 path is active, or when the clock is stopped. The divide-by-1 path is the crystal clock itself, passed through a latch-based gate whose enable can only change while the crystal clock is low. The divided ratios come from a registered phase flop.

Top module: `card_clk_divider`

## Requirements
- R1: The select code sets the ratio: 00 gives divide by 8, 01 gives divide by 4, 11 gives divide by 2 and 10 gives divide by 1 (code bit 1 is `rate_sel[1]`).
- R2: In steady state at ratio N, every high phase and every low phase of `card_clk` lasts N/2 crystal periods. For N = 1 each phase follows one half-period of the crystal clock.
- R3: Across a ratio change, no complete high or low phase of `card_clk` is shorter than half the shorter of the old and new output periods.
- R4: The first high phase at the new ratio begins no later than 10 crystal periods after the first crystal rising edge that follows a select change.
- R5: When `run_en` falls, the current high phase finishes at full length. Then `card_clk` goes low within 10 crystal periods and stays low.
- R6: When `run_en` rises from the stopped state, the first high phase has full length and begins within 10 crystal periods.
- R7: While `rst` is high, and after it until `run_en` is set, `card_clk` is low. Reset selects divide by 8 in the stopped state.
- R8: The divided-phase path and the divide-by-1 path are never enabled together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock, source of all timing |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Ratio select code, asynchronous |
| run_en | input | 1 | Start (1) or stop (0) request from the sequencer, asynchronous |
| card_clk | output | 1 | Divided, gated card clock |

## Verification
A wrong counter terminal or a wrong decoded ratio shows up within one output period as high or low runs of the wrong length. An adoption at an unsafe point shows up at the transition itself as a run shorter than the shorter half-period. A stuck or lost synchronized select shows up by the tenth crystal period after the change, because the first run at the new length never appears. The bench samples `card_clk` in both halves of every crystal period. This resolves each run to half a crystal period, so the divide-by-1 phases and any half-period runt are visible directly.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
  // Largest ratio is 2**MAX_LOG
  localparam int unsigned MAX_LOG = 3;
  localparam int unsigned LOG_W   = $clog2(MAX_LOG + 1);

  typedef logic [LOG_W-1:0] ratio_log_t;

  // Non-binary select code to log2 of the ratio
  function automatic ratio_log_t sel_to_log(input logic [1:0] code);
    case (code)
      2'b00:   return ratio_log_t'(3);
      2'b01:   return ratio_log_t'(2);
      2'b11:   return ratio_log_t'(1);
      default: return ratio_log_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/ckdiv_sync.sv
`timescale 1ns/1ps
module ckdiv_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ckdiv_ctrl.sv
`timescale 1ns/1ps
module ckdiv_ctrl
  import ckdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_s,
  input  logic [1:0] sel_s,
  output logic       phase_o,
  output logic       bypass_en_o
);
  localparam int unsigned CNT_W = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;

  logic             running;
  logic             bypass_en;
  logic             phase;
  ratio_log_t       cur_log;
  ratio_log_t       new_log;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             safe;

  assign new_log = sel_to_log(sel_s);

  // Half-period terminal count for the current divided ratio
  always_comb begin
    term = '0;
    for (int i = 1; i <= int'(MAX_LOG); i++) begin
      if (cur_log == ratio_log_t'(i)) term = CNT_W'((1 << (i - 1)) - 1);
    end
  end

  // A setting may be adopted when stopped, when the bypass path runs,
  // or when the divided phase is low and about to rise
  assign safe = !running || bypass_en || (!phase && (cnt == term));

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      bypass_en <= 1'b0;
      phase     <= 1'b0;
      cnt       <= '0;
      cur_log   <= ratio_log_t'(MAX_LOG);
    end else if (safe) begin
      cnt <= '0;
      if (!run_s) begin
        running   <= 1'b0;
        bypass_en <= 1'b0;
        phase     <= 1'b0;
      end else begin
        running   <= 1'b1;
        cur_log   <= new_log;
        bypass_en <= (new_log == '0);
        phase     <= (new_log != '0);
      end
    end else if (cnt == term) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase_o     = phase;
  assign bypass_en_o = bypass_en;

  p_ratio_r1: assert property (@(posedge clk) disable iff (rst)
    (running && !bypass_en) |-> (cur_log != '0));

  p_half_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (running && !bypass_en && (cnt != term)) |=> $stable(phase));

  p_adopt_low_r3: assert property (@(posedge clk) disable iff (rst)
    (cur_log != $past(cur_log)) |-> !$past(phase));

  p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> !$past(phase));

  p_one_path_r8: assert property (@(posedge clk) disable iff (rst)
    !(phase && bypass_en));
endmodule

// File: rtl/ckdiv_outgate.sv
`timescale 1ns/1ps
module ckdiv_outgate (
  input  logic clk,
  input  logic bypass_en,
  input  logic phase,
  output logic clk_out
);
  logic en_lat;

  // Enable is transparent only while the clock is low
  always_latch begin
    if (!clk) en_lat = bypass_en;
  end

  assign clk_out = (clk & en_lat) | phase;
endmodule

// File: rtl/card_clk_divider.sv
`timescale 1ns/1ps
module card_clk_divider #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_xtal,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  input  logic       run_en,
  output logic       card_clk
);
  localparam int unsigned SYNC_W = 3;

  logic [SYNC_W-1:0] ctl_s;
  logic              phase;
  logic              bypass_en;

  ckdiv_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_xtal),
    .rst (rst),
    .d   ({run_en, rate_sel}),
    .q   (ctl_s)
  );

  ckdiv_ctrl u_ctrl (
    .clk         (clk_xtal),
    .rst         (rst),
    .run_s       (ctl_s[2]),
    .sel_s       (ctl_s[1:0]),
    .phase_o     (phase),
    .bypass_en_o (bypass_en)
  );

  ckdiv_outgate u_gate (
    .clk       (clk_xtal),
    .bypass_en (bypass_en),
    .phase     (phase),
    .clk_out   (card_clk)
  );

  p_reset_low_r7: assert property (@(posedge clk_xtal)
    $past(rst) |-> !phase);
endmodule

// File: tb/card_clk_divider_bench.sv
`timescale 1ns/1ps
module card_clk_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 120;

  logic       clk_xtal = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] rate_sel = 2'b00;
  logic       run_en = 1'b0;
  wire        card_clk;

  int n_chk = 0;
  int n_bad = 0;
  bit smp [NS];

  card_clk_divider u_card_clk_divider (
    .clk_xtal (clk_xtal),
    .rst      (rst),
    .rate_sel (rate_sel),
    .run_en   (run_en),
    .card_clk (card_clk)
  );

  always #(CLK_PERIOD / 2) clk_xtal = ~clk_xtal;

  function automatic int ratio_of(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  // Two samples per crystal period: in the high half and in the low half
  task automatic grab(input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk_xtal);
      #(CLK_PERIOD * 0.25) smp[2*i]   = card_clk;
      #(CLK_PERIOD * 0.5)  smp[2*i+1] = card_clk;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Shortest complete run (bounded by transitions on both sides)
  function automatic int min_run(input int len);
    int s = 0;
    int m = 999;
    for (int i = 1; i <= len; i++) begin
      if (i == len || smp[i] != smp[i-1]) begin
        if (s > 0 && i < len && (i - s) < m) m = i - s;
        s = i;
      end
    end
    return m;
  endfunction

  function automatic int first_high(input int len, input int n);
    int s = 0;
    for (int i = 1; i <= len; i++) begin
      if (i == len || smp[i] != smp[i-1]) begin
        if (s > 0 && i < len && smp[s] && (i - s) == n) return s;
        s = i;
      end
    end
    return -1;
  endfunction

  // Length of the first complete run from 'from' onward that is not n, 0 if none
  function automatic int bad_run(input int from, input int len, input int n);
    int s = 0;
    for (int i = 1; i <= len; i++) begin
      if (i == len || smp[i] != smp[i-1]) begin
        if (s >= from && s > 0 && i < len && (i - s) != n) return i - s;
        s = i;
      end
    end
    return 0;
  endfunction

  function automatic int run_count(input int from, input int len);
    int s = 0;
    int c = 0;
    for (int i = 1; i <= len; i++) begin
      if (i == len || smp[i] != smp[i-1]) begin
        if (s >= from && s > 0 && i < len) c++;
        s = i;
      end
    end
    return c;
  endfunction

  function automatic int ones_from(input int from, input int len);
    int c = 0;
    for (int i = from; i < len; i++) c += int'(smp[i]);
    return c;
  endfunction

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic steady_checks(input int n, input string tag);
    int b;
    int c;
    b = bad_run(40, NS, n);
    c = run_count(40, NS);
    check(b == 0, {tag, " R1 R2 run length"}, b, n);
    check(c >= 2, {tag, " R2 run count"}, c, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog(all) actual=%0d expected=%0d", 1, 0);
    summary_and_end();
  end

  initial begin
    int nold;
    int nnew;
    int fh;
    int mr;
    int bit_i;
    logic [1:0] nsel;

    void'($urandom(32'h5EED_0017));

    // R7: low during reset and while stopped afterwards
    grab(4);
    check(ones_from(2, 8) == 0, "R7 low in reset", ones_from(2, 8), 0);
    rst = 1'b0;
    grab(20);
    check(ones_from(0, 40) == 0, "R7 low after reset", ones_from(0, 40), 0);

    // R6: start from stopped at divide by 8
    run_en = 1'b1;
    grab(60);
    fh = first_high(NS, 8);
    check(fh >= 0 && fh <= 20, "R6 start latency", fh, 20);
    mr = min_run(NS);
    check(mr >= 8, "R6 full first phase", mr, 8);
    steady_checks(8, "div8");

    // R3 R4 R1 R2: random single-bit select changes
    for (int it = 0; it < 14; it++) begin
      bit_i = int'($urandom % 2);
      nsel = rate_sel ^ (2'b01 << bit_i);
      nold = ratio_of(rate_sel);
      nnew = ratio_of(nsel);
      rate_sel = nsel;
      grab(60);
      mr = min_run(NS);
      check(mr >= ((nold < nnew) ? nold : nnew), "R3 no runt across change", mr,
            (nold < nnew) ? nold : nnew);
      fh = first_high(NS, nnew);
      check(fh >= 0 && fh <= 20, "R4 change latency", fh, 20);
      steady_checks(nnew, "rand");
    end

    // R5: stop from a divided ratio (divide by 4)
    rate_sel = 2'b01;
    grab(40);
    run_en = 1'b0;
    grab(60);
    check(ones_from(20, NS) == 0, "R5 stops low div4", ones_from(20, NS), 0);
    mr = min_run(NS);
    check(mr >= 4, "R5 no short phase div4", mr, 4);

    // R6: restart at divide by 1
    rate_sel = 2'b00;
    grab(10);
    rate_sel = 2'b10;
    grab(10);
    run_en = 1'b1;
    grab(60);
    fh = first_high(NS, 1);
    check(fh >= 0 && fh <= 20, "R6 start latency div1", fh, 20);
    steady_checks(1, "div1");

    // R5: stop from divide by 1
    run_en = 1'b0;
    grab(60);
    check(ones_from(20, NS) == 0, "R5 stops low div1", ones_from(20, NS), 0);

    // R7: reset while running at divide by 2
    rate_sel = 2'b11;
    run_en = 1'b1;
    grab(40);
    rst = 1'b1;
    grab(6);
    check(ones_from(4, 12) == 0, "R7 reset forces low", ones_from(4, 12), 0);
    rst = 1'b0;
    grab(60);
    fh = first_high(NS, 2);
    check(fh >= 0 && fh <= 20, "R7 R4 resume after reset", fh, 20);

    summary_and_end();
  end
endmodule